// File: doc/BRIEF.md
# Dual-Mode Serial Byte Encoder

This block carries bytes from a transponder reader front end to a host microcontroller over one output wire. It sends two kinds of byte. The first is a diagnostic byte, emitted a fixed delay after a charge phase starts. The second is the stream of demodulated data bytes produced during a read session. Data bytes pass through a small buffer, which absorbs the gap between the slow demodulator and the faster link. Each data byte is inverted before it goes out.

Two line disciplines are supported.

- **Asynchronous mode.** The encoder frames each byte with a high start bit and a low stop bit, using a fixed bit time. The line rests low between frames.
- **Synchronous mode.** The encoder raises the line to announce that a byte is ready. The host then clocks the byte out with falling edges on the shared control wire.

A read session ends in one of three ways:

- the control wire goes low (asynchronous mode);
- the control wire is held low for a long time while no byte is being clocked (synchronous mode);
- the read session timer runs out.

When a session ends, any buffered data is discarded.

Top module: `resp_byte_link`

## Requirements
- R1: In asynchronous mode, a frame is a high start bit, then the eight byte bits least significant first, then a low stop bit. Each bit lasts BIT_CYC cycles, and the line is low whenever no frame is being sent.
- R2: A data byte appears on the line as the bitwise complement of `rx_byte`. A diagnostic byte appears with its bits unchanged.
- R3: DIAG_DELAY_CYC cycles after a `charge_start` pulse, the diagnostic byte is selected and sent. Its value is 0xAF when `osc_ok` is high and no bridge trip has been seen.
- R4: The diagnostic byte is 0xFF in either of two cases: `osc_ok` is low at the moment of selection, or `bridge_trip` was high in any cycle from the charge start up to the selection.
- R5: When a diagnostic byte and a buffered data byte are both waiting for a free transmitter, the diagnostic byte is sent first.
- R6: Within a read session, data bytes that arrive before the first byte flagged by `rx_first` are dropped. The flagged byte is the first data byte sent.
- R7: Up to FIFO_DEPTH (4) data bytes wait in the buffer. On overflow, the newest byte is dropped and `ovf_flag` is set. `ovf_flag` stays set until the next `read_start`.
- R8: In synchronous mode, `ser_out` goes high when a byte is ready. Each of eight falling edges on `ctl_line` puts the next bit on `ser_out`, least significant first. After the eighth edge, the line returns low once `ctl_line` rises.
- R9: In asynchronous mode, `ctl_line` low during a read session ends the session. Any frame in flight is aborted, with the line driven low, and buffered bytes are discarded. Data arriving later is ignored until the next `read_start`.
- R10: READ_TO_CYC cycles after `read_start`, the read session ends and later data is ignored.
- R11: In synchronous mode, `ctl_line` held low for more than STOP_LOW_CYC cycles while no byte is being clocked ends the session. A long low in the middle of a byte is only a slow shift clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_mode | input | 1 | 1 selects host-clocked synchronous transfer |
| ctl_line | input | 1 | Shared control wire from the host (asynchronous to `clk`) |
| charge_start | input | 1 | One-cycle pulse marking the start of a charge phase |
| osc_ok | input | 1 | Antenna oscillation detected |
| bridge_trip | input | 1 | A bridge driver was shut down by overcurrent |
| read_start | input | 1 | One-cycle pulse opening a read session |
| rx_valid | input | 1 | A demodulated byte is presented this cycle |
| rx_first | input | 1 | The presented byte is the detected start byte |
| rx_byte | input | 8 | Demodulated byte, in transponder polarity |
| ser_out | output | 1 | Serial line to the host |
| ovf_flag | output | 1 | Sticky buffer overflow indication |

## Verification
Two functions can compete in the same cycle. The diagnostic delay can expire while a data frame is still on the line and another data byte is already buffered. In that case the free transmitter sees both a pending diagnostic byte and a non-empty buffer at once. The bench provokes this by issuing `charge_start` shortly after a read session begins, so the delay runs out partway through the first data frame while a second byte waits. It then judges the byte order decoded from the line: inverted start byte, then 0xAF, then the second inverted byte.

// File: rtl/resp_link_pkg.sv
package resp_link_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_ASYNC,
    TX_READY,
    TX_SHIFT,
    TX_TAIL
  } tx_state_e;

  localparam int unsigned FRAME_BITS = 10;
  localparam logic [7:0]  DIAG_GOOD  = 8'hAF;
  localparam logic [7:0]  DIAG_FAIL  = 8'hFF;
endpackage

// File: rtl/resp_ctl_sync.sv
// Brings the host control wire into the clock domain, finds its edges and
// reports a low phase that has lasted LOW_LIMIT cycles (R11).
module resp_ctl_sync #(
  parameter int unsigned LOW_LIMIT = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_in,
  output logic lvl,
  output logic fall,
  output logic rise,
  output logic long_low
);
  localparam int unsigned LW = $clog2(LOW_LIMIT + 1);

  logic          s1_q, s2_q, prev_q;
  logic [LW-1:0] low_q, low_n;

  always_comb begin
    if (s2_q)                        low_n = '0;
    else if (low_q == LW'(LOW_LIMIT)) low_n = low_q;
    else                             low_n = low_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      low_q  <= '0;
    end else begin
      s1_q   <= ctl_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      low_q  <= low_n;
    end
  end

  assign lvl      = s2_q;
  assign fall     = prev_q & ~s2_q;
  assign rise     = ~prev_q & s2_q;
  assign long_low = (low_q == LW'(LOW_LIMIT));
endmodule

// File: rtl/resp_byte_fifo.sv
// Small byte buffer; a write to a full buffer is dropped and flagged (R7).
module resp_byte_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         ovf_clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         vld,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         ovf
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ovf_q, ovf_n;
  logic          full, wr, rd;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full   = (cnt_q == CW'(DEPTH));
    rd     = pop & (cnt_q != '0);
    wr     = push & (~full | rd);
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    ovf_n  = ovf_q | (push & ~wr);
    if (ovf_clr) ovf_n = 1'b0;
    if (clr) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
    end else begin
      if (wr) wptr_n = bump(wptr_q);
      if (rd) rptr_n = bump(rptr_q);
      cnt_n = cnt_q + CW'(wr) - CW'(rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
      ovf_q  <= ovf_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr && !clr && wptr_q == PW'(i)) mem_q[i] <= din;
    end
  end

  assign dout = mem_q[rptr_q];
  assign vld  = (cnt_q != '0);
  assign cnt  = cnt_q;
  assign ovf  = ovf_q;
endmodule

// File: rtl/resp_frame_tx.sv
// Byte transmitter: framed timed bits (R1) or host-clocked bits (R8).
// A waiting diagnostic byte is taken before buffered data (R5).
module resp_frame_tx
  import resp_link_pkg::*;
#(
  parameter int unsigned BIT_CYC = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_mode,
  input  logic       abort,
  input  logic       diag_vld,
  input  logic [7:0] diag_byte,
  input  logic       fifo_vld,
  input  logic [7:0] fifo_byte,
  input  logic       ctl_fall,
  input  logic       ctl_rise,
  output logic       diag_take,
  output logic       fifo_pop,
  output logic       shifting,
  output logic       ser_out
);
  localparam int unsigned TW = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;

  tx_state_e st_q, st_n;
  logic [FRAME_BITS-1:0] sh_q, sh_n;
  logic [3:0]            bit_q, bit_n;
  logic [TW-1:0]         tmr_q, tmr_n;
  logic                  out_q, out_n;
  logic [7:0]            pick;

  always_comb begin
    st_n      = st_q;
    sh_n      = sh_q;
    bit_n     = bit_q;
    tmr_n     = tmr_q;
    out_n     = out_q;
    diag_take = 1'b0;
    fifo_pop  = 1'b0;
    pick      = diag_vld ? diag_byte : fifo_byte;
    if (abort) begin
      st_n  = TX_IDLE;
      out_n = 1'b0;
    end else begin
      case (st_q)
        TX_IDLE: begin
          out_n = 1'b0;
          if (diag_vld || fifo_vld) begin
            diag_take = diag_vld;
            fifo_pop  = ~diag_vld;
            bit_n     = '0;
            tmr_n     = '0;
            out_n     = 1'b1;
            if (sync_mode) begin
              st_n = TX_READY;
              sh_n = {2'b00, pick};
            end else begin
              st_n = TX_ASYNC;
              sh_n = {1'b0, pick, 1'b1};
            end
          end
        end
        TX_ASYNC: begin
          if (tmr_q == TW'(BIT_CYC - 1)) begin
            tmr_n = '0;
            if (bit_q == 4'(FRAME_BITS - 1)) begin
              st_n  = TX_IDLE;
              out_n = 1'b0;
            end else begin
              bit_n = bit_q + 1'b1;
              sh_n  = sh_q >> 1;
              out_n = sh_q[1];
            end
          end else begin
            tmr_n = tmr_q + 1'b1;
          end
        end
        TX_READY: begin
          if (ctl_fall) begin
            out_n = sh_q[0];
            sh_n  = sh_q >> 1;
            bit_n = 4'd1;
            st_n  = TX_SHIFT;
          end
        end
        TX_SHIFT: begin
          if (ctl_fall) begin
            out_n = sh_q[0];
            sh_n  = sh_q >> 1;
            bit_n = bit_q + 1'b1;
            if (bit_q == 4'd7) st_n = TX_TAIL;
          end
        end
        TX_TAIL: begin
          if (ctl_rise) begin
            st_n  = TX_IDLE;
            out_n = 1'b0;
          end
        end
        default: begin
          st_n  = TX_IDLE;
          out_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      sh_q  <= '0;
      bit_q <= '0;
      tmr_q <= '0;
      out_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      sh_q  <= sh_n;
      bit_q <= bit_n;
      tmr_q <= tmr_n;
      out_q <= out_n;
    end
  end

  assign shifting = (st_q == TX_SHIFT) || (st_q == TX_TAIL);
  assign ser_out  = out_q;
endmodule

// File: rtl/resp_byte_link.sv
// Top: read session control, diagnostic byte timing and selection,
// data inversion, buffering and the transmitter.
module resp_byte_link
  import resp_link_pkg::*;
#(
  parameter int unsigned BIT_CYC        = 1024,
  parameter int unsigned FIFO_DEPTH     = 4,
  parameter int unsigned DIAG_DELAY_CYC = 32000,
  parameter int unsigned READ_TO_CYC    = 320000,
  parameter int unsigned STOP_LOW_CYC   = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_mode,
  input  logic       ctl_line,
  input  logic       charge_start,
  input  logic       osc_ok,
  input  logic       bridge_trip,
  input  logic       read_start,
  input  logic       rx_valid,
  input  logic       rx_first,
  input  logic [7:0] rx_byte,
  output logic       ser_out,
  output logic       ovf_flag
);
  localparam int unsigned RW = $clog2(READ_TO_CYC + 1);
  localparam int unsigned DW = $clog2(DIAG_DELAY_CYC + 1);
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

  // reset: asserted at once, released through two flops
  logic rst_s1_q, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_n_i  <= rst_s1_q;
    end
  end

  logic ctl_lvl, ctl_fall, ctl_rise, ctl_long;
  resp_ctl_sync #(.LOW_LIMIT(STOP_LOW_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n_i), .ctl_in(ctl_line),
    .lvl(ctl_lvl), .fall(ctl_fall), .rise(ctl_rise), .long_low(ctl_long)
  );

  // read session (R6, R9, R10, R11)
  logic          session_q, session_n, gate_q, gate_n;
  logic [RW-1:0] rtmr_q, rtmr_n;
  logic          tx_shifting, stop_now, fifo_push;

  always_comb begin
    stop_now  = session_q & ~read_start &
                ( (rtmr_q == RW'(1))
                | (~sync_mode & ~ctl_lvl)
                | (sync_mode & ctl_long & ~tx_shifting) );
    fifo_push = session_q & ~stop_now & ~read_start & rx_valid & (gate_q | rx_first);
    session_n = session_q;
    gate_n    = gate_q;
    rtmr_n    = rtmr_q;
    if (read_start) begin
      session_n = 1'b1;
      gate_n    = 1'b0;
      rtmr_n    = RW'(READ_TO_CYC);
    end else if (stop_now) begin
      session_n = 1'b0;
      rtmr_n    = '0;
    end else if (session_q) begin
      rtmr_n = rtmr_q - 1'b1;
      if (fifo_push) gate_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      session_q <= 1'b0;
      gate_q    <= 1'b0;
      rtmr_q    <= '0;
    end else begin
      session_q <= session_n;
      gate_q    <= gate_n;
      rtmr_q    <= rtmr_n;
    end
  end

  // diagnostic byte (R3, R4)
  logic [DW-1:0] dcnt_q, dcnt_n;
  logic          trip_q, trip_n, dpend_q, dpend_n;
  logic [7:0]    dbyte_q, dbyte_n;
  logic          diag_take;

  always_comb begin
    dcnt_n  = dcnt_q;
    trip_n  = trip_q;
    dpend_n = dpend_q & ~diag_take;
    dbyte_n = dbyte_q;
    if (charge_start) begin
      dcnt_n = DW'(DIAG_DELAY_CYC);
      trip_n = bridge_trip;
    end else if (dcnt_q != '0) begin
      dcnt_n = dcnt_q - 1'b1;
      trip_n = trip_q | bridge_trip;
      if (dcnt_q == DW'(1)) begin
        dpend_n = 1'b1;
        dbyte_n = (~osc_ok | trip_q | bridge_trip) ? DIAG_FAIL : DIAG_GOOD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      dcnt_q  <= '0;
      trip_q  <= 1'b0;
      dpend_q <= 1'b0;
      dbyte_q <= '0;
    end else begin
      dcnt_q  <= dcnt_n;
      trip_q  <= trip_n;
      dpend_q <= dpend_n;
      dbyte_q <= dbyte_n;
    end
  end

  // buffer holds bytes already in line polarity (R2, R7)
  logic [7:0]    fifo_dout;
  logic          fifo_vld, fifo_pop;
  logic [CW-1:0] fifo_cnt;

  resp_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n_i), .clr(stop_now | read_start), .ovf_clr(read_start),
    .push(fifo_push), .din(~rx_byte), .pop(fifo_pop),
    .dout(fifo_dout), .vld(fifo_vld), .cnt(fifo_cnt), .ovf(ovf_flag)
  );

  resp_frame_tx #(.BIT_CYC(BIT_CYC)) u_tx (
    .clk(clk), .rst_n(rst_n_i), .sync_mode(sync_mode), .abort(stop_now),
    .diag_vld(dpend_q), .diag_byte(dbyte_q),
    .fifo_vld(fifo_vld), .fifo_byte(fifo_dout),
    .ctl_fall(ctl_fall), .ctl_rise(ctl_rise),
    .diag_take(diag_take), .fifo_pop(fifo_pop),
    .shifting(tx_shifting), .ser_out(ser_out)
  );
endmodule

// File: rtl/resp_byte_link_chk.sv
module resp_byte_link_chk #(
  parameter int unsigned DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       read_start,
  input logic                       ser_out,
  input logic                       ovf_flag,
  input logic                       session_on,
  input logic                       stop_now,
  input logic                       fifo_pop,
  input logic                       diag_pend,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
  assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !read_start) |=> ovf_flag);

  assert_stop_quiets_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |=> !ser_out);

  assert_session_end_flushes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(session_on) |-> (fifo_cnt == '0));

  assert_diag_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !diag_pend);
endmodule

bind resp_byte_link resp_byte_link_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .read_start(read_start), .ser_out(ser_out),
  .ovf_flag(ovf_flag), .session_on(session_q), .stop_now(stop_now),
  .fifo_pop(fifo_pop), .diag_pend(dpend_q), .fifo_cnt(fifo_cnt)
);

// File: tb/resp_byte_link_tb.sv
`timescale 1ns/1ps
module resp_byte_link_tb;
  localparam int BITC  = 16;
  localparam int DDLY  = 40;
  localparam int RTO   = 3000;
  localparam int SLOW  = 64;
  localparam int WMAX  = 600;

  logic clk = 1'b0;
  logic rst_n, sync_mode, ctl_line, charge_start, osc_ok, bridge_trip;
  logic read_start, rx_valid, rx_first;
  logic [7:0] rx_byte;
  logic ser_out, ovf_flag;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  resp_byte_link #(
    .BIT_CYC(BITC), .FIFO_DEPTH(4), .DIAG_DELAY_CYC(DDLY),
    .READ_TO_CYC(RTO), .STOP_LOW_CYC(SLOW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .ctl_line(ctl_line),
    .charge_start(charge_start), .osc_ok(osc_ok), .bridge_trip(bridge_trip),
    .read_start(read_start), .rx_valid(rx_valid), .rx_first(rx_first),
    .rx_byte(rx_byte), .ser_out(ser_out), .ovf_flag(ovf_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_read();
    @(negedge clk); read_start = 1'b1;
    @(negedge clk); read_start = 1'b0;
  endtask

  task automatic pulse_charge();
    @(negedge clk); charge_start = 1'b1;
    @(negedge clk); charge_start = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input logic first);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b; rx_first = first;
    @(negedge clk); rx_valid = 1'b0; rx_first = 1'b0;
  endtask

  // waits for a start bit, then decodes one asynchronous frame
  task automatic recv(output logic [7:0] b, output int hw, output logic stopv, output bit got);
    int wd = 0;
    bit run = 1;
    b = '0; hw = 0; stopv = 1'bx; got = 0;
    while (ser_out !== 1'b1 && wd < WMAX) begin @(negedge clk); wd++; end
    if (ser_out !== 1'b1) return;
    got = 1;
    for (int c = 0; c < 10*BITC; c++) begin
      if (run && ser_out === 1'b1) hw++; else run = 0;
      if (c % BITC == BITC/2) begin
        if (c/BITC >= 1 && c/BITC <= 8) b[c/BITC-1] = ser_out;
        if (c/BITC == 9) stopv = ser_out;
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_frame(input logic [7:0] exp, input string tag);
    logic [7:0] b; int hw; logic sv; bit got;
    recv(b, hw, sv, got);
    chk(got, {tag, " frame seen"}, 32'(got), 1);
    chk(b === exp, {tag, " byte"}, 32'(b), 32'(exp));
    chk(sv === 1'b0, {tag, " R1 stop bit low"}, 32'(sv), 0);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      if (ser_out !== 1'b0) seen = 1;
      @(negedge clk);
    end
    chk(!seen, tag, 32'(seen), 0);
  endtask

  // one host shift clock in synchronous mode; extra stretches the low phase
  task automatic sclk(input int extra, output logic v);
    ctl_line = 1'b0; cyc(6 + extra);
    v = ser_out;
    ctl_line = 1'b1; cyc(6);
  endtask

  task automatic t_reset();
    chk(ser_out === 1'b0, "R1 line low after reset", 32'(ser_out), 0);
    chk(ovf_flag === 1'b0, "R7 overflow clear after reset", 32'(ovf_flag), 0);
    expect_quiet(40, "R1 idle line stays low");
  endtask

  task automatic t_diag_ok();
    int n = 0;
    osc_ok = 1'b1;
    pulse_charge();
    while (ser_out !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    chk(n >= DDLY && n <= DDLY + 2, "R3 diagnostic delay", 32'(n), 32'(DDLY + 1));
    expect_frame(8'hAF, "R3 R2 good diagnostic");
  endtask

  task automatic t_diag_fail();
    pulse_charge();
    cyc(10);
    @(negedge clk); bridge_trip = 1'b1;
    @(negedge clk); bridge_trip = 1'b0;
    expect_frame(8'hFF, "R4 bridge trip during delay");
    osc_ok = 1'b0;
    pulse_charge();
    expect_frame(8'hFF, "R4 no oscillation");
    osc_ok = 1'b1;
  endtask

  task automatic t_gate_invert();
    logic [7:0] b0, b1; int h0, h1; logic s0, s1; bit g0, g1;
    pulse_read();
    push(8'h12, 1'b0);
    expect_quiet(30, "R6 byte before start byte dropped");
    fork
      begin recv(b0, h0, s0, g0); recv(b1, h1, s1, g1); end
      begin push(8'h7E, 1'b1); cyc(20); push(8'h35, 1'b0); end
    join
    chk(g0 && b0 === 8'h81, "R6 R2 start byte first and inverted", 32'(b0), 32'h81);
    chk(g1 && b1 === 8'hCA, "R2 data byte inverted", 32'(b1), 32'hCA);
    chk(h1 == BITC, "R1 start bit length", 32'(h1), 32'(BITC));
    chk(s0 === 1'b0 && s1 === 1'b0, "R1 stop bits low", 32'({s0, s1}), 0);
  endtask

  // diag expiry lands inside a data frame while another byte is buffered
  task automatic t_priority();
    logic [7:0] b [3]; int h; logic s; bit g;
    pulse_read();
    fork
      begin for (int i = 0; i < 3; i++) recv(b[i], h, s, g); end
      begin push(8'hA0, 1'b1); cyc(5); push(8'h0F, 1'b0); pulse_charge(); end
    join
    chk(b[0] === 8'h5F, "R5 first frame data", 32'(b[0]), 32'h5F);
    chk(b[1] === 8'hAF, "R5 diagnostic ahead of buffered data", 32'(b[1]), 32'hAF);
    chk(b[2] === 8'hF0, "R5 buffered data after diagnostic", 32'(b[2]), 32'hF0);
  endtask

  task automatic t_overflow();
    logic [7:0] b [5]; int h; logic s; bit g;
    logic [7:0] exp [5] = '{8'hFE, 8'hEE, 8'hDD, 8'hCC, 8'hBB};
    pulse_read();
    fork
      begin for (int i = 0; i < 5; i++) recv(b[i], h, s, g); end
      begin
        push(8'h01, 1'b1);
        cyc(5);
        for (int i = 1; i <= 5; i++) begin
          @(negedge clk); rx_valid = 1'b1; rx_byte = 8'(i * 8'h11);
        end
        @(negedge clk); rx_valid = 1'b0;
      end
    join
    for (int i = 0; i < 5; i++)
      chk(b[i] === exp[i], "R7 kept bytes in order", 32'(b[i]), 32'(exp[i]));
    chk(ovf_flag === 1'b1, "R7 overflow flagged", 32'(ovf_flag), 1);
    expect_quiet(200, "R7 newest byte dropped");
    chk(ovf_flag === 1'b1, "R7 overflow sticky", 32'(ovf_flag), 1);
    pulse_read();
    cyc(2);
    chk(ovf_flag === 1'b0, "R7 overflow cleared by read start", 32'(ovf_flag), 0);
  endtask

  task automatic t_async_stop();
    pulse_read();
    push(8'h0F, 1'b1);
    cyc(40);
    ctl_line = 1'b0;
    cyc(6);
    chk(ser_out === 1'b0, "R9 frame aborted", 32'(ser_out), 0);
    expect_quiet(100, "R9 line stays low after stop");
    push(8'h55, 1'b1);
    expect_quiet(200, "R9 data ignored after stop");
    ctl_line = 1'b1;
    cyc(5);
  endtask

  task automatic t_timeout();
    pulse_read();
    cyc(RTO - 300);
    fork
      expect_frame(8'hC3, "R10 data before timeout");
      push(8'h3C, 1'b1);
    join
    cyc(200);
    push(8'h3C, 1'b1);
    expect_quiet(200, "R10 data ignored after timeout");
  endtask

  task automatic t_sync();
    logic v;
    logic [7:0] got;
    @(negedge clk); sync_mode = 1'b1;
    pulse_read();
    push(8'h3C, 1'b1);
    cyc(8);
    chk(ser_out === 1'b1, "R8 ready level", 32'(ser_out), 1);
    for (int i = 0; i < 8; i++) begin
      sclk((i == 3) ? 100 : 0, v);
      got[i] = v;
    end
    chk(got === 8'hC3, "R8 R2 bits clocked out", 32'(got), 32'hC3);
    chk(ser_out === 1'b0, "R8 line low after byte", 32'(ser_out), 0);
    push(8'h5A, 1'b0);
    cyc(8);
    chk(ser_out === 1'b1, "R11 session kept after long low mid-byte", 32'(ser_out), 1);
    for (int i = 0; i < 8; i++) begin
      sclk(0, v);
      got[i] = v;
    end
    chk(got === 8'hA5, "R8 second byte", 32'(got), 32'hA5);
  endtask

  task automatic t_sync_stop();
    ctl_line = 1'b0;
    cyc(100);
    ctl_line = 1'b1;
    cyc(5);
    push(8'h00, 1'b1);
    expect_quiet(100, "R11 long idle low ends session");
    @(negedge clk); sync_mode = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync_mode = 1'b0; ctl_line = 1'b1; charge_start = 1'b0;
    osc_ok = 1'b1; bridge_trip = 1'b0; read_start = 1'b0;
    rx_valid = 1'b0; rx_first = 1'b0; rx_byte = '0;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_diag_ok();
    t_diag_fail();
    t_gate_invert();
    t_priority();
    t_overflow();
    t_async_stop();
    t_timeout();
    t_sync();
    t_sync_stop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule